// File: doc/BRIEF.md
# Programmed I/O Flag Unit

This block is the input/output unit of a small accumulator machine. It holds an input byte register with a ready flag, an output byte register with a ready flag, and an interrupt-enable bit. When the control unit enables it, it executes one I/O instruction in a single cycle. Input and output instructions move bytes between the accumulator's low byte and the two registers. Skip instructions tell the program counter to step over the next instruction when a flag is set. Two further instructions turn interrupts on and off.

Each device sees a simple ready-flag protocol. The input device presents a byte with a strobe, which sets the input flag. An INP instruction clears that flag again. OUT clears the output flag, and the output device sets it back once it has taken the byte. The interrupt request is formed from the enable bit and the two flags. A byte that arrives while the input flag is still set is dropped and counted in a saturating overrun counter.

Top module: `pio_flag_unit`

## Requirements
- R1: After reset the input flag is 0 and the output flag is 1. Interrupts are disabled, the output register and overrun count are 0, and the interrupt request is low.
- R2: An instruction is executed only in a cycle where `ioEn` is 1 and `instr[15:12]` is 4'b1111. In any other cycle `acLoad`, `pcSkip` and `done` stay low and no register or flag changes.
- R3: INP (`instr[11]`) raises `acLoad` in its own cycle, and the input flag is clear from the next cycle. `acData` always shows the input register.
- R4: OUT (`instr[10]`) loads `acLow` into the output register, visible on `outByte` in the next cycle, and clears the output flag.
- R5: In its own cycle, SKI (`instr[9]`) raises `pcSkip` if the input flag is 1, and SKO (`instr[8]`) raises `pcSkip` if the output flag is 1.
- R6: ION (`instr[7]`) sets the interrupt enable and IOF (`instr[6]`) clears it. When both bits are set in one instruction, IOF wins.
- R7: A `devInStb` pulse while the input flag is 0 loads `devInByte` and sets the flag. A pulse while the flag is 1 changes neither the register nor the flag, and it adds one to `overrunCnt`, which saturates at its all-ones value.
- R8: `devOutTaken` sets the output flag. If OUT executes in the same cycle, the flag ends cleared.
- R9: A `devInStb` pulse that arrives while the input flag is 0, in the same cycle as INP, leaves the flag set and the new byte in the register.
- R10: In every cycle, `intReq` equals enable AND (input flag OR output flag).
- R11: `done` is high for exactly the cycles in which an instruction executes. Set operation bits combine, and each one acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioEn | input | 1 | Execute enable from the control unit |
| instr | input | 16 | Instruction word |
| acLow | input | DATA_W | Accumulator low byte |
| acLoad | output | 1 | Load strobe for the accumulator low byte |
| acData | output | DATA_W | Input register contents |
| pcSkip | output | 1 | Request to increment the program counter |
| done | output | 1 | Instruction-complete pulse |
| devInStb | input | 1 | Input device byte strobe |
| devInByte | input | DATA_W | Input device byte |
| devOutTaken | input | 1 | Output device has taken the byte |
| outByte | output | DATA_W | Output register contents |
| intReq | output | 1 | Interrupt request |
| overrunCnt | output | OVR_W | Saturating count of dropped input bytes |

## Verification
A flag can be set by a device and cleared by an instruction in the same cycle. The bench forces both collisions on purpose. It issues INP in the same cycle as an input strobe that arrives while the input flag is clear, and it issues OUT in the same cycle as an output-taken pulse. It then judges the outcome through SKI, SKO, `acData` and `intReq` on the cycles that follow. A long run of random instructions and device pulses is compared each cycle against a behavioural model that applies the same priority rules. That run also covers strobes that arrive while the flag is set, and ION with IOF together.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int INSTR_W = 16;
  localparam int OPC_HI  = 15;
  localparam int OPC_LO  = 12;
  localparam logic [OPC_HI-OPC_LO:0] IO_OPCODE = '1;
  localparam int INP_BIT = 11;
  localparam int OUT_BIT = 10;
  localparam int SKI_BIT = 9;
  localparam int SKO_BIT = 8;
  localparam int ION_BIT = 7;
  localparam int IOF_BIT = 6;

  typedef struct packed {
    logic inp;
    logic out;
    logic ski;
    logic sko;
    logic ion;
    logic iof;
    logic done;
  } ioStrobes_t;
endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
(
  input  logic               ioEn,
  input  logic [INSTR_W-1:0] instr,
  output ioStrobes_t         stb
);
  logic hit;
  logic unusedLowBits;

  assign unusedLowBits = ^instr[IOF_BIT-1:0];
  assign hit = ioEn && (instr[OPC_HI:OPC_LO] == IO_OPCODE);

  always_comb begin
    stb.inp  = hit & instr[INP_BIT];
    stb.out  = hit & instr[OUT_BIT];
    stb.ski  = hit & instr[SKI_BIT];
    stb.sko  = hit & instr[SKO_BIT];
    stb.ion  = hit & instr[ION_BIT];
    stb.iof  = hit & instr[IOF_BIT];
    stb.done = hit;
  end
endmodule

// File: rtl/pio_dp.sv
module pio_dp
  import pio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVR_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ioStrobes_t        stb,
  input  logic [DATA_W-1:0] acLow,
  input  logic              devInStb,
  input  logic [DATA_W-1:0] devInByte,
  input  logic              devOutTaken,
  output logic              acLoad,
  output logic [DATA_W-1:0] acData,
  output logic              pcSkip,
  output logic              done,
  output logic [DATA_W-1:0] outByte,
  output logic              intReq,
  output logic [OVR_W-1:0]  overrunCnt
);
  localparam logic [OVR_W-1:0] OVR_MAX = '1;

  logic [DATA_W-1:0] inReg, outReg;
  logic              inFlag, outFlag, intEn;
  logic [OVR_W-1:0]  ovrCnt;
  logic              acceptIn, dropIn;

  assign acceptIn = devInStb && !inFlag;
  assign dropIn   = devInStb && inFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inReg  <= '0;
      inFlag <= 1'b0;
      ovrCnt <= '0;
    end else begin
      if (acceptIn) inReg <= devInByte;
      if (acceptIn) inFlag <= 1'b1;
      else if (stb.inp) inFlag <= 1'b0;
      if (dropIn && ovrCnt != OVR_MAX) ovrCnt <= ovrCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outReg  <= '0;
      outFlag <= 1'b1;
    end else if (stb.out) begin
      outReg  <= acLow;
      outFlag <= 1'b0;
    end else if (devOutTaken) begin
      outFlag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) intEn <= 1'b0;
    else if (stb.iof) intEn <= 1'b0;
    else if (stb.ion) intEn <= 1'b1;
  end

  assign acLoad     = stb.inp;
  assign acData     = inReg;
  assign pcSkip     = (stb.ski & inFlag) | (stb.sko & outFlag);
  assign done       = stb.done;
  assign outByte    = outReg;
  assign intReq     = intEn & (inFlag | outFlag);
  assign overrunCnt = ovrCnt;
endmodule

// File: rtl/pio_flag_unit.sv
module pio_flag_unit
  import pio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVR_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ioEn,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  acLow,
  output logic               acLoad,
  output logic [DATA_W-1:0]  acData,
  output logic               pcSkip,
  output logic               done,
  input  logic               devInStb,
  input  logic [DATA_W-1:0]  devInByte,
  input  logic               devOutTaken,
  output logic [DATA_W-1:0]  outByte,
  output logic               intReq,
  output logic [OVR_W-1:0]   overrunCnt
);
  ioStrobes_t stb;

  pio_ctrl u_ctrl (
    .ioEn (ioEn),
    .instr(instr),
    .stb  (stb)
  );

  pio_dp #(.DATA_W(DATA_W), .OVR_W(OVR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .acLow      (acLow),
    .devInStb   (devInStb),
    .devInByte  (devInByte),
    .devOutTaken(devOutTaken),
    .acLoad     (acLoad),
    .acData     (acData),
    .pcSkip     (pcSkip),
    .done       (done),
    .outByte    (outByte),
    .intReq     (intReq),
    .overrunCnt (overrunCnt)
  );
endmodule

// File: rtl/pio_chk.sv
module pio_chk #(
  parameter int DATA_W = 8,
  parameter int OVR_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              ioEn,
  input logic [15:0]       instr,
  input logic [DATA_W-1:0] acLow,
  input logic              acLoad,
  input logic [DATA_W-1:0] acData,
  input logic              pcSkip,
  input logic              done,
  input logic              devInStb,
  input logic [DATA_W-1:0] devInByte,
  input logic              devOutTaken,
  input logic [DATA_W-1:0] outByte,
  input logic              intReq,
  input logic [OVR_W-1:0]  overrunCnt
);
  logic unusedIn;
  assign unusedIn = ^devInByte;

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ioEn && instr[15:12] == 4'hF) |-> (!acLoad && !pcSkip && !done));

  // R4
  out_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && instr[10]) |=> (outByte == $past(acLow)));

  // R7
  in_reg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !devInStb |=> $stable(acData));

  // R7
  ovr_monotonic_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrunCnt >= $past(overrunCnt));

  // R6
  iof_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && instr[6]) |=> !intReq);

  // R8
  taken_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && instr[7] && !instr[6] && !instr[10] && devOutTaken) |=> intReq);
endmodule

bind pio_flag_unit pio_chk #(.DATA_W(DATA_W), .OVR_W(OVR_W)) u_chk (.*);

// File: tb/sim_pio_flag_unit.sv
`timescale 1ns/1ps
module sim_pio_flag_unit;
  localparam int DW = 8;
  localparam int CW = 4;
  localparam int OVR_MAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ioEn = 1'b0;
  logic [15:0] instr = '0;
  logic [DW-1:0] acLow = '0;
  logic acLoad, pcSkip, done, intReq;
  logic [DW-1:0] acData, outByte;
  logic devInStb = 1'b0;
  logic [DW-1:0] devInByte = '0;
  logic devOutTaken = 1'b0;
  logic [CW-1:0] overrunCnt;

  always #10 clk = ~clk;

  pio_flag_unit #(.DATA_W(DW), .OVR_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .ioEn(ioEn), .instr(instr), .acLow(acLow),
    .acLoad(acLoad), .acData(acData), .pcSkip(pcSkip), .done(done),
    .devInStb(devInStb), .devInByte(devInByte), .devOutTaken(devOutTaken),
    .outByte(outByte), .intReq(intReq), .overrunCnt(overrunCnt)
  );

  int checks = 0;
  int fails = 0;
  string note = "";
  bit finished = 0;

  // behavioural reference state
  bit mFgi, mFgo, mIen;
  int mInpr, mOutr, mOvr;

  task automatic check(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", tag, note, got, exp, $time);
    end
  endtask

  task automatic modelReset();
    mFgi = 0; mFgo = 1; mIen = 0; mInpr = 0; mOutr = 0; mOvr = 0;
  endtask

  task automatic step(input bit en, input logic [15:0] ins, input int ac,
                      input bit inStb, input int inByte, input bit taken);
    bit valid;
    bit setI;
    ioEn = en; instr = ins; acLow = DW'(ac);
    devInStb = inStb; devInByte = DW'(inByte); devOutTaken = taken;
    #2;
    valid = en && ins[15:12] == 4'hF;
    check(acLoad, valid && ins[11], "R3");
    check(acData, mInpr, "R3");
    check(pcSkip, valid && ((ins[9] && mFgi) || (ins[8] && mFgo)), "R5");
    check(done, valid, "R11");
    check(intReq, mIen && (mFgi || mFgo), "R10");
    check(outByte, mOutr, "R4");
    check(overrunCnt, mOvr, "R7");
    @(posedge clk);
    setI = 0;
    if (inStb) begin
      if (mFgi) begin
        if (mOvr < OVR_MAX) mOvr++;
      end else begin
        mInpr = inByte & 8'hFF;
        setI = 1;
      end
    end
    if (setI) mFgi = 1;
    else if (valid && ins[11]) mFgi = 0;
    if (valid && ins[10]) begin mOutr = ac & 8'hFF; mFgo = 0; end
    else if (taken) mFgo = 1;
    if (valid && ins[6]) mIen = 0;
    else if (valid && ins[7]) mIen = 1;
    @(negedge clk);
  endtask

  task automatic idle(); step(0, 16'h0000, 0, 0, 0, 0); endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    #2;
    note = "reset";
    check(intReq, 0, "R1");
    check(outByte, 0, "R1");
    check(overrunCnt, 0, "R1");
    check(acData, 0, "R1");
    rstN = 1'b1;
    @(negedge clk);

    note = "R1 flags after reset";
    step(1, 16'hF200, 0, 0, 0, 0);     // SKI: no skip
    step(1, 16'hF100, 0, 0, 0, 0);     // SKO: skip

    note = "R2 non-io or disabled";
    step(1, 16'h7C00, 8'h5A, 0, 0, 0); // I bit clear
    step(0, 16'hF400, 8'h5A, 0, 0, 0); // not enabled
    step(1, 16'hE300, 8'h5A, 0, 0, 0);
    idle();
    check(outByte, 0, "R2");

    note = "R4 out";
    step(1, 16'hF400, 8'hA5, 0, 0, 0);
    step(1, 16'hF100, 0, 0, 0, 0);     // SKO: no skip now
    step(0, 0, 0, 0, 0, 1);            // device takes byte
    step(1, 16'hF100, 0, 0, 0, 0);     // skip again

    note = "R3 input then inp";
    step(0, 0, 0, 1, 8'h3C, 0);
    step(1, 16'hF200, 0, 0, 0, 0);
    step(1, 16'hF800, 0, 0, 0, 0);
    step(1, 16'hF200, 0, 0, 0, 0);
    check(acData, 8'h3C, "R3");

    note = "R7 overrun";
    step(0, 0, 0, 1, 8'h11, 0);
    step(0, 0, 0, 1, 8'h22, 0);
    idle();
    check(acData, 8'h11, "R7");
    check(overrunCnt, 1, "R7");
    for (int i = 0; i < 20; i++) step(0, 0, 0, 1, i, 0);
    idle();
    check(overrunCnt, OVR_MAX, "R7");

    note = "R6 ion iof";
    step(1, 16'hF080, 0, 0, 0, 0);
    idle();
    check(intReq, 1, "R6");
    step(1, 16'hF040, 0, 0, 0, 0);
    step(1, 16'hF080, 0, 0, 0, 0);
    step(1, 16'hF0C0, 0, 0, 0, 0);
    idle();
    check(intReq, 0, "R6");

    note = "R8 out with taken";
    step(1, 16'hF800, 0, 0, 0, 0);     // clear input flag
    step(1, 16'hF480, 8'h77, 0, 0, 1);
    idle();
    check(intReq, 0, "R8");
    step(1, 16'hF100, 0, 0, 0, 0);

    note = "R9 inp with strobe";
    step(1, 16'hF800, 0, 1, 8'h9E, 0);
    idle();
    check(intReq, 1, "R9");
    check(acData, 8'h9E, "R9");
    step(1, 16'hF200, 0, 0, 0, 0);

    note = "R11 combined ops";
    step(1, 16'hFF00, 8'h42, 0, 0, 0);
    step(1, 16'hF300, 0, 0, 0, 0);

    note = "R10 random";
    for (int i = 0; i < 600; i++) begin
      logic [15:0] ins;
      ins = 16'($urandom);
      if ($urandom % 4 != 0) ins[15:12] = 4'hF;
      step(($urandom % 3) != 0, ins, $urandom % 256,
           ($urandom % 3) == 0, $urandom % 256, ($urandom % 4) == 0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule